// File: doc/BRIEF.md
# Interrupt Pending and Mask Register Unit

This block keeps the pending and mask state for sixty-four level-sensitive interrupt sources and gates them into request lines. On every clock it captures the raw source levels into a pending vector. A sixty-four-bit mask, held as two thirty-two-bit halves, blocks individual sources. A set mask bit blocks its source; a clear bit lets it through. The unit drives a registered per-source request vector and one combined request line. A downstream priority or vectoring stage uses these outputs; this block does no arbitration.

Software reaches the state through a small thirty-two-bit register port. A two-bit address picks one of four words. Address 0 is the lower mask word (sources 0..31) and address 1 is the upper mask word (sources 32..63). Address 2 is the lower pending word and address 3 is the upper pending word. Reads are combinational from the selected word. A write takes effect at the clock edge where the write strobe is high. One control path exists for software that must silence everything at once. Any write to the lower mask word with bit 0 set turns on all sixty-four mask bits, whatever the other data bits hold.

Top module: `irq_pend_mask`

## Requirements
- R1: After reset, both mask words read 0xFFFFFFFF, both pending words read 0, the request vector is 0 and the combined request is low.
- R2: Request bit i is high exactly when pending bit i was 1 and mask bit i was 0 in the cycle before. A mask value of 1 blocks the request.
- R3: A write to address 0 or address 1 loads the lower or upper mask word. Reading the same address afterwards returns the stored value.
- R4: A write to address 0 whose data bit 0 is 1 sets all sixty-four mask bits to 1, whatever the other data bits are.
- R5: A write to address 0 with data bit 0 equal to 0 changes only the lower mask word. A write to address 1 changes only the upper word and never sets all bits, even when its data bit 0 is 1.
- R6: Each pending bit i (1..63) holds the level that source i had at the previous clock edge. Pending bits 0..31 are read at address 2 and bits 32..63 at address 3.
- R7: A pending bit follows its source even when the matching mask bit is 1.
- R8: Pending bit 0 is reserved and always reads 0. Request bit 0 is therefore always 0.
- R9: Writes to addresses 2 and 3 change no state. Pending reads, mask reads and requests are unaffected.
- R10: The request vector and the combined request are registered one cycle after the pending sample. The combined request is high exactly when at least one request bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Word select: 0 mask low, 1 mask high, 2 pending low, 3 pending high |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq_src | input | 64 | Raw level interrupt inputs, bit i is source i |
| irq_req | output | 64 | Masked request vector |
| irq_any | output | 1 | OR of the request vector |

## Verification
The bench goes after the lower-word write with bit 0 set. A design that decoded this write wrongly would leave the upper mask word open, or would also set all bits on an upper-word write. It checks that masked sources still show as pending. A design that gated the pending capture with the mask would read zero there. It drives source 0 high and writes to the pending addresses. A design that kept the reserved bit, or that let pending words be written, would show the wrong pending value. Requests are compared every cycle against a model with a two-stage delay. This catches a design that gates the requests through the mask without the register stage, or one that uses a stale mask.

// File: rtl/irq_pm_pkg.sv
package irq_pm_pkg;

    typedef enum logic [1:0] {
        SEL_MASK_LO = 2'd0,
        SEL_MASK_HI = 2'd1,
        SEL_PEND_LO = 2'd2,
        SEL_PEND_HI = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_pend_sampler.sv
module irq_pend_sampler #(
    parameter int unsigned NSRC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    output logic [NSRC-1:0] pend_o
);

    typedef struct packed {
        logic [NSRC-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pend = src_i;
        st_d.pend[0] = 1'b0;        // reserved slot
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R6 and R7: every live slot tracks its source regardless of the mask
    p_pend_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_o[NSRC-1:1] == $past(src_i[NSRC-1:1]));

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [DW-1:0] wdata_i,
    output logic [2*DW-1:0] mask_o
);

    localparam int unsigned NHALF = 2;

    typedef struct packed {
        logic [NHALF-1:0][DW-1:0] half;
    } state_t;

    state_t st_d, st_q;
    logic [NHALF-1:0] half_wr;
    logic             all_set;

    assign half_wr = {wr_hi_i, wr_lo_i};
    assign all_set = wr_lo_i && wdata_i[0];

    always_comb begin
        st_d = st_q;
        for (int h = 0; h < NHALF; h++) begin
            if (all_set)         st_d.half[h] = '1;
            else if (half_wr[h]) st_d.half[h] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.half;

    // R4: global mask-all on lower-word write with bit 0 set
    p_mask_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && wdata_i[0]) |=> mask_o == '1);

    // R5: lower-word write without bit 0 keeps the upper word
    p_hi_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !wdata_i[0] && !wr_hi_i) |=> mask_o[2*DW-1:DW] == $past(mask_o[2*DW-1:DW]));

    // R5: upper-word write never touches the lower word
    p_lo_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !wr_lo_i) |=> mask_o[DW-1:0] == $past(mask_o[DW-1:0]));

endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
    parameter int unsigned NSRC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] req_o,
    output logic            any_o
);

    typedef struct packed {
        logic [NSRC-1:0] req;
        logic            any;
    } state_t;

    state_t st_d, st_q;
    logic [NSRC-1:0] open_v;

    assign open_v = pend_i & ~mask_i;

    always_comb begin
        st_d = st_q;
        st_d.req = open_v;
        st_d.any = |open_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;
    assign any_o = st_q.any;

    // R2: no request is raised for a source that was masked the cycle before
    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_o & $past(mask_i)) == '0);

    // R10: a request appears one cycle after an unmasked pending bit
    p_req_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> req_o == ($past(pend_i) & ~$past(mask_i)));

endmodule

// File: rtl/irq_pend_mask.sv
module irq_pend_mask #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [63:0]   irq_src,
    output logic [63:0]   irq_req,
    output logic          irq_any
);

    import irq_pm_pkg::*;

    localparam int unsigned NSRC = 2 * DW;

    reg_sel_e        sel;
    logic            wr_lo, wr_hi;
    logic [NSRC-1:0] pend, mask;

    assign sel   = reg_sel_e'(reg_addr);
    assign wr_lo = reg_wr && (sel == SEL_MASK_LO);
    assign wr_hi = reg_wr && (sel == SEL_MASK_HI);

    irq_pend_sampler #(.NSRC(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (irq_src),
        .pend_o (pend)
    );

    irq_mask_regs #(.DW(DW)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .wdata_i (reg_wdata),
        .mask_o  (mask)
    );

    irq_req_gate #(.NSRC(NSRC)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .mask_i (mask),
        .req_o  (irq_req),
        .any_o  (irq_any)
    );

    always_comb begin
        unique case (sel)
            SEL_MASK_LO: reg_rdata = mask[DW-1:0];
            SEL_MASK_HI: reg_rdata = mask[NSRC-1:DW];
            SEL_PEND_LO: reg_rdata = pend[DW-1:0];
            default:     reg_rdata = pend[NSRC-1:DW];
        endcase
    end

    // R10: combined line agrees with the vector it summarises
    p_any_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (irq_req != '0));

    // R8: reserved request slot stays low
    p_rsvd_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req[0]);

endmodule

// File: tb/sim_irq_pend_mask.sv
`timescale 1ns/1ps
module sim_irq_pend_mask;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] irq_src = '0;
    logic [63:0] irq_req;
    logic        irq_any;

    always #2 clk = ~clk;

    irq_pend_mask u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_src(irq_src),
        .irq_req(irq_req), .irq_any(irq_any)
    );

    int n_run = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [63:0] m_mask = '1;
    logic [63:0] m_pend = '0;
    logic [63:0] m_req  = '0;
    logic        m_any  = 1'b0;

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_mask[31:0];
            2'd1:    return m_mask[63:32];
            2'd2:    return m_pend[31:0];
            default: return m_pend[63:32];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, check read data, model at posedge, check outputs
    task automatic step(input logic [1:0] a, input logic w, input logic [31:0] d,
                        input logic [63:0] s, input string tag);
        reg_addr = a; reg_wr = w; reg_wdata = d; irq_src = s;
        #1;
        chk(tag, {32'd0, reg_rdata}, {32'd0, model_read(a)});
        @(posedge clk);
        m_req = m_pend & ~m_mask;
        m_any = |m_req;
        m_pend = s & ~64'd1;
        if (w && a == 2'd0 && d[0]) m_mask = '1;
        else if (w && a == 2'd0)    m_mask[31:0] = d;
        else if (w && a == 2'd1)    m_mask[63:32] = d;
        @(negedge clk);
        chk("R2 req", irq_req, m_req);
        chk("R10 any", {63'd0, irq_any}, {63'd0, m_any});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 req", irq_req, 64'd0);
        chk("R1 any", {63'd0, irq_any}, 64'd0);
        for (int a = 0; a < 4; a++) step(a[1:0], 1'b0, 32'd0, 64'd0, "R1 read");
        // R7: sources arrive while fully masked, pending still follows
        step(2'd2, 1'b0, 0, 64'hA5A5_0F0F_3C3C_F0F2, "R7 pre");
        step(2'd2, 1'b0, 0, 64'h0000_0000_0000_0000, "R7 pend lo");
        step(2'd3, 1'b0, 0, 64'h1234_5678_9ABC_DEF0, "R7 pend hi");
        // R5: lower write with bit0 clear leaves upper
        step(2'd0, 1'b1, 32'hFFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R5 wr");
        step(2'd1, 1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R5 hi kept");
        step(2'd0, 1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R3 lo read");
        // R3: upper write; R5: its bit0 does not mask all
        step(2'd1, 1'b1, 32'h0000_00F1, 64'hFFFF_FFFF_FFFF_FFFF, "R3 wr");
        step(2'd1, 1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R3 hi read");
        step(2'd0, 1'b0, 0, 64'h0000_00F0_0000_0001, "R5 lo after hi");
        // R8: source 0 high, reserved pending bit stays 0
        step(2'd2, 1'b0, 0, 64'h0000_0000_0000_0001, "R8 pend bit0");
        step(2'd2, 1'b0, 0, 64'h0000_0000_0000_0001, "R8 pend bit0");
        // R9: writes to pending words ignored
        step(2'd2, 1'b1, 32'hFFFF_FFFF, 64'd0, "R9 wr lo");
        step(2'd3, 1'b1, 32'hFFFF_FFFF, 64'd0, "R9 wr hi");
        step(2'd2, 1'b0, 0, 64'd0, "R9 pend lo");
        step(2'd3, 1'b0, 0, 64'd0, "R9 pend hi");
        step(2'd0, 1'b0, 0, 64'd0, "R9 mask lo");
        // R4: mask-all
        step(2'd0, 1'b1, 32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFFE, "R4 wr");
        step(2'd1, 1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFE, "R4 hi");
        step(2'd0, 1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFE, "R4 lo");
        // open all, then R6 patterns
        step(2'd1, 1'b1, 32'd0, 64'd0, "R3 open hi");
        step(2'd0, 1'b1, 32'd0, 64'd0, "R3 open lo");
        for (int i = 0; i < 64; i++) begin
            step({1'b1, i[5]}, 1'b0, 0, 64'd1 << i, "R6 walk");
        end
        for (int k = 0; k < 400; k++) begin
            logic [1:0]  a = 2'($urandom);
            logic        w = ($urandom % 4) == 0;
            logic [31:0] d = $urandom;
            if (($urandom % 3) != 0) d[0] = 1'b0;
            step(a, w, d, {$urandom, $urandom}, "R6 R3 random");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

endmodule